// File: doc/BRIEF.md
# Transmit Staging FIFO with Refill Watermark and Start Threshold

This block buffers outgoing frame bytes between a host or DMA engine and a byte-serial transmitter. The fill side delivers 16-bit words, each of which carries either two bytes or a single final byte. Each word can also be tagged as the end of its frame. The drain side hands bytes to the transmitter one per handshake, and each byte carries a flag that marks the last byte of a frame.

The block also drives two pacing signals. `refillReq` asks the buffer manager for more data. It is high while the empty space can take at least a programmed number of 16-bit transfers. `startTx` tells the transmitter it may begin sending the frame at the head of the queue. It is high once enough bytes of that frame have been written, or as soon as the whole frame is stored. Both settings are 2-bit codes that can change at any time and take effect immediately.

Top module: `tx_stage_fifo`

## Requirements
- R1: After reset the FIFO is empty: `rdValid`=0, `startTx`=0, `wrReady`=1, and `refillReq`=1 for every `wmSel` code.
- R2: A two-byte write stores `wrData[7:0]` ahead of `wrData[15:8]`. With `wrOneByte`=1, only `wrData[7:0]` is stored. Bytes leave in the order they were stored.
- R3: `wrReady` is low exactly when fewer than 2 bytes are free. A write offered while `wrReady` is low is dropped and overwrites nothing.
- R4: `rdValid` is low exactly when the FIFO is empty. A read offered while it is low has no effect.
- R5: `refillReq` is high exactly when floor(free bytes / 2) is at least N. N is 8, 16, 32 and 32 for `wmSel` codes 00, 01, 10 and 11.
- R6: While no end-of-frame byte is stored, `startTx` is high exactly when the bytes written for the head frame reach T. T is 4, 16, 64 and 112 for `startSel` codes 00, 01, 10 and 11. Bytes of the head frame already read still count toward T.
- R7: While at least one end-of-frame byte is stored, `startTx` is high whatever `startSel` holds.
- R8: Reading an end-of-frame byte restarts the head-frame byte count from the bytes now stored. `startTx` falls unless the next frame qualifies under R6 or R7.
- R9: `rdEof` is high only on the byte stored by an end-of-frame write. That byte is the high byte of a two-byte write, or the single byte when `wrOneByte`=1.
- R10: A write and a read accepted in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wmSel | input | 2 | Refill watermark code |
| startSel | input | 2 | Start threshold code |
| wrValid | input | 1 | Write word offered |
| wrReady | output | 1 | Room for a write word |
| wrData | input | 16 | Write word, low byte first |
| wrOneByte | input | 1 | Only the low byte is valid |
| wrEof | input | 1 | Word ends a frame |
| rdValid | output | 1 | A byte is available |
| rdReady | input | 1 | Transmitter takes the byte |
| rdData | output | 8 | Head byte |
| rdEof | output | 1 | Head byte ends its frame |
| refillReq | output | 1 | Empty space meets the watermark |
| startTx | output | 1 | Head frame may start transmission |

## Verification
Several input patterns are used, and each one separates different failures:
- A two-byte word followed by a single-byte end word shows whether the byte order or the placement of the end flag is wrong.
- Filling to full and then draining to empty walks the free space across every watermark boundary, with the code switched along the way.
- Back-to-back frames, short frames with an end mark, and long frames without one tell the threshold path apart from the end-of-frame bypass. They also show whether the count is re-derived when a frame's last byte leaves.
- A long stretch of mixed writes and reads, with both codes changing, makes simultaneous push and pop and pointer wraparound common.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;

  typedef struct packed {
    logic push;
    logic pushTwo;
    logic pop;
  } fifoStrobe_t;

  function automatic int unsigned startBytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 112;
    endcase
  endfunction

  function automatic int unsigned refillXfers(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tx_fifo_dp.sv
module tx_fifo_dp
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fifoStrobe_t           strobe,
  input  logic [2*BYTE_W-1:0]   wrWord,
  input  logic                  wrEof,
  output logic [BYTE_W-1:0]     rdData,
  output logic                  rdEof
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LANES = 2;

  logic [BYTE_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] laneAddr [LANES];
  logic             laneEn   [LANES];
  logic [BYTE_W:0]  laneWord [LANES];

  // Lane 0 is the low byte and is always written first; the end flag
  // lands on whichever lane holds the last byte of the word.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneAddr[l] = wrPtr + PTR_W'(l);
      laneEn[l]   = strobe.push && ((l == 0) || strobe.pushTwo);
      laneWord[l] = {wrEof && ((l == LANES - 1) || !strobe.pushTwo),
                     wrWord[l*BYTE_W +: BYTE_W]};
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (laneEn[l]) mem[laneAddr[l]] <= laneWord[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + (strobe.pushTwo ? PTR_W'(2) : PTR_W'(1));
      if (strobe.pop)  rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  assign rdData = mem[rdPtr][BYTE_W-1:0];
  assign rdEof  = mem[rdPtr][BYTE_W];

endmodule

// File: rtl/tx_fifo_ctrl.sv
module tx_fifo_ctrl
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        wrOneByte,
  input  logic        wrEof,
  output logic        wrReady,
  input  logic        rdReady,
  output logic        rdValid,
  input  logic        headEof,
  input  logic [1:0]  wmSel,
  input  logic [1:0]  startSel,
  output logic        refillReq,
  output logic        startTx,
  output fifoStrobe_t strobe
);
  localparam int unsigned CNT_W  = $clog2(DEPTH) + 1;
  localparam int unsigned HEAD_W = CNT_W;
  localparam logic [HEAD_W-1:0] HEAD_MAX = '1;

  logic [CNT_W-1:0]  count, countNext, freeBytes, inBytes;
  logic [CNT_W-1:0]  eofCnt, eofNext;
  logic [HEAD_W-1:0] headCnt, headNext;
  logic [HEAD_W:0]   headSum;

  always_comb begin
    freeBytes      = CNT_W'(DEPTH) - count;
    wrReady        = freeBytes >= CNT_W'(2);
    rdValid        = count != '0;
    strobe.push    = wrValid && wrReady;
    strobe.pushTwo = !wrOneByte;
    strobe.pop     = rdReady && rdValid;

    inBytes = '0;
    if (strobe.push) inBytes = strobe.pushTwo ? CNT_W'(2) : CNT_W'(1);
    countNext = count + inBytes - CNT_W'(strobe.pop);
    eofNext   = eofCnt + CNT_W'(strobe.push && wrEof) - CNT_W'(strobe.pop && headEof);

    // Head-frame byte count: re-derived from occupancy when a frame's last
    // byte leaves (everything left belongs to the next frame), otherwise
    // grown by writes while the head frame is still open.
    headSum  = {1'b0, headCnt} + {1'b0, inBytes};
    headNext = headCnt;
    if (strobe.pop && headEof)
      headNext = countNext;
    else if (strobe.push && (eofCnt == '0))
      headNext = headSum[HEAD_W] ? HEAD_MAX : headSum[HEAD_W-1:0];

    refillReq = 32'(freeBytes >> 1) >= refillXfers(wmSel);
    startTx   = (eofCnt != '0) || (32'(headCnt) >= startBytes(startSel));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      eofCnt  <= '0;
      headCnt <= '0;
    end else begin
      count   <= countNext;
      eofCnt  <= eofNext;
      headCnt <= headNext;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) <= DEPTH);

  assert_drain_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(1) && strobe.pop && !strobe.push) |=> !rdValid);

  assert_refill_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(refillReq) && $stable(wmSel)) |-> $past(strobe.push));

  assert_eof_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && wrEof) |=> startTx);

endmodule

// File: rtl/tx_stage_fifo.sv
module tx_stage_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          wmSel,
  input  logic [1:0]          startSel,
  input  logic                wrValid,
  output logic                wrReady,
  input  logic [2*BYTE_W-1:0] wrData,
  input  logic                wrOneByte,
  input  logic                wrEof,
  output logic                rdValid,
  input  logic                rdReady,
  output logic [BYTE_W-1:0]   rdData,
  output logic                rdEof,
  output logic                refillReq,
  output logic                startTx
);
  fifoStrobe_t strobe;
  logic        headEof;

  tx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .wrOneByte (wrOneByte),
    .wrEof     (wrEof),
    .wrReady   (wrReady),
    .rdReady   (rdReady),
    .rdValid   (rdValid),
    .headEof   (headEof),
    .wmSel     (wmSel),
    .startSel  (startSel),
    .refillReq (refillReq),
    .startTx   (startTx),
    .strobe    (strobe)
  );

  tx_fifo_dp #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrWord (wrData),
    .wrEof  (wrEof),
    .rdData (rdData),
    .rdEof  (headEof)
  );

  assign rdEof = headEof;

endmodule

// File: tb/tx_stage_fifo_tb_top.sv
module tx_stage_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  wmSel, startSel;
  logic        wrValid, wrOneByte, wrEof, rdReady;
  logic [15:0] wrData;
  logic        wrReady, rdValid, rdEof, refillReq, startTx;
  logic [7:0]  rdData;

  int checks = 0;
  int fails  = 0;

  logic [8:0] q[$];
  int         head;
  bit         lastAcc;
  logic [7:0] seq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_stage_fifo dut_i (
    .clk(clk), .rstN(rstN), .wmSel(wmSel), .startSel(startSel),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .wrOneByte(wrOneByte), .wrEof(wrEof), .rdValid(rdValid),
    .rdReady(rdReady), .rdData(rdData), .rdEof(rdEof),
    .refillReq(refillReq), .startTx(startTx)
  );

  function automatic int thrOf(input logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 16 : (c == 2'b10) ? 64 : 112;
  endfunction

  function automatic int wmOf(input logic [1:0] c);
    return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 32;
  endfunction

  function automatic int eofs();
    int n = 0;
    foreach (q[i]) if (q[i][8]) n++;
    return n;
  endfunction

  function automatic bit mReady();  return (DEPTH - q.size()) >= 2; endfunction
  function automatic bit mStart();  return eofs() > 0 || head >= thrOf(startSel); endfunction
  function automatic bit mRefill(); return ((DEPTH - q.size()) / 2) >= wmOf(wmSel); endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compareAll();
    checkEq("R3 wrReady", int'(wrReady), int'(mReady()));
    checkEq("R4 rdValid", int'(rdValid), int'(q.size() > 0));
    if (q.size() > 0) begin
      checkEq("R2 rdData", int'(rdData), int'(q[0][7:0]));
      checkEq("R9 rdEof", int'(rdEof), int'(q[0][8]));
    end
    checkEq("R5 refillReq", int'(refillReq), int'(mRefill()));
    checkEq("R6 R7 R8 startTx", int'(startTx), int'(mStart()));
  endtask

  task automatic step(input bit wv, input logic [15:0] wd, input bit one,
                      input bit eof, input bit rr);
    bit popv, popEof, acc;
    int eofBefore;
    #1;
    compareAll();
    wrValid = wv; wrData = wd; wrOneByte = one; wrEof = eof; rdReady = rr;
    acc       = wv && mReady();
    popv      = rr && (q.size() > 0);
    popEof    = popv && q[0][8];
    eofBefore = eofs();
    @(posedge clk);
    if (popv) void'(q.pop_front());
    if (acc) begin
      if (one) q.push_back({eof, wd[7:0]});
      else begin
        q.push_back({1'b0, wd[7:0]});
        q.push_back({eof, wd[15:8]});
      end
    end
    if (popEof) head = q.size();
    else if (acc && eofBefore == 0) head += one ? 1 : 2;
    lastAcc = acc;
    @(negedge clk);
    #1;
  endtask

  task automatic writeFrame(input int n, input bit eofEnd, input bit rr);
    int done = 0;
    while (done < n) begin
      bit one = (n - done == 1);
      bit e   = eofEnd && (n - done <= 2);
      step(1'b1, {seq + 8'd1, seq}, one, e, rr);
      if (lastAcc) begin
        done += one ? 1 : 2;
        seq  += 8'd2;
      end
    end
  endtask

  task automatic drainAll(output int got);
    got = 0;
    while (q.size() > 0) begin
      step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
      got++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int got;
    logic [15:0] lfsr;
    rstN = 1'b0; wmSel = 2'b10; startSel = 2'b10;
    wrValid = 0; wrData = 0; wrOneByte = 0; wrEof = 0; rdReady = 0;
    head = 0; seq = 8'h01;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    checkEq("R1 rdValid", int'(rdValid), 0);
    checkEq("R1 startTx", int'(startTx), 0);
    checkEq("R1 wrReady", int'(wrReady), 1);
    for (int c = 0; c < 4; c++) begin
      wmSel = 2'(c);
      #1 checkEq("R1 refillReq", int'(refillReq), 1);
    end
    wmSel = 2'b10;

    // R2 / R9: byte order and end flag placement
    step(1'b1, 16'hBBAA, 1'b0, 1'b0, 1'b0);
    step(1'b1, 16'h00CC, 1'b1, 1'b1, 1'b0);
    checkEq("R2 first byte", int'(rdData), 'hAA);
    checkEq("R9 no eof on first", int'(rdEof), 0);
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    checkEq("R2 second byte", int'(rdData), 'hBB);
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    checkEq("R2 single byte", int'(rdData), 'hCC);
    checkEq("R9 eof on single", int'(rdEof), 1);
    drainAll(got);

    // R6: threshold of 4 bytes
    startSel = 2'b00;
    writeFrame(2, 1'b0, 1'b0);
    checkEq("R6 below threshold", int'(startTx), 0);
    writeFrame(2, 1'b0, 1'b0);
    checkEq("R6 at threshold", int'(startTx), 1);
    writeFrame(1, 1'b1, 1'b0);
    drainAll(got);
    checkEq("R8 start drops after eof read", int'(startTx), 0);
    checkEq("R4 empty after drain", int'(rdValid), 0);
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    checkEq("R4 read on empty ignored", int'(rdValid), 0);

    // R7: short complete frame bypasses a high threshold
    startSel = 2'b11;
    writeFrame(3, 1'b1, 1'b0);
    checkEq("R7 complete frame starts", int'(startTx), 1);
    drainAll(got);

    // R8: recount at end-of-frame consumption
    startSel = 2'b01;
    writeFrame(10, 1'b1, 1'b0);
    writeFrame(20, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    checkEq("R8 next frame keeps start", int'(startTx), 1);
    writeFrame(1, 1'b1, 1'b0);
    writeFrame(5, 1'b0, 1'b0);
    for (int i = 0; i < 21; i++) step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    checkEq("R8 short next frame drops start", int'(startTx), 0);
    writeFrame(11, 1'b1, 1'b0);
    drainAll(got);

    // R3 / R5: fill to full, refuse extra writes, sweep watermark
    startSel = 2'b10;
    writeFrame(DEPTH, 1'b0, 1'b0);
    checkEq("R3 full refuses", int'(wrReady), 0);
    step(1'b1, 16'hDEAD, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < DEPTH; k++) begin
      wmSel = 2'(k % 4);
      step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    end
    checkEq("R3 no byte overwritten or added", int'(rdValid), 0);
    wmSel = 2'b00;

    // R10: simultaneous push and pop at mid occupancy
    writeFrame(50, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      step(1'b1, {seq + 8'd1, seq}, 1'b0, (i % 9) == 8, 1'b1);
      seq += 8'd2;
    end
    checkEq("R10 occupancy held", int'(q.size() > 60), 1);
    drainAll(got);

    // Mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((i % 300) == 0) begin
        wmSel = lfsr[1:0];
        startSel = lfsr[3:2];
      end
      step(lfsr[4] | lfsr[9], {lfsr[7:0], lfsr[15:8]}, lfsr[5] & lfsr[6],
           lfsr[7] & lfsr[8] & lfsr[11], lfsr[10] | (lfsr[12] & (i > 2000)));
    end
    drainAll(got);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule